// File: doc/BRIEF.md
# Quarter-Gate Programmable Delay Line

This block is a cycle-accurate model of a programmable edge-delay path. One clock cycle stands for a quarter of a basic gate delay. A single-bit signal enters a shift chain. A tap multiplexer picks the stage that drives the output. The total delay is a fixed base latency plus a 7-bit tap code counted in quarter-gate units. An extra-quarter select adds one more unit, so that the full setting reaches exactly 32 gate delays.

The tap code and the extra-quarter select are captured at every clock edge. A new setting therefore takes effect at the next edge. Bits already travelling down the chain keep their place and are not re-timed. A force-low input, captured on the same edge, holds the output low while it is high. It does not disturb the chain, so the delayed stream reappears once it drops.

Top module: `prog_delay_line`

## Requirements
- R1: At every rising clock edge the chain captures `sig_in` into its first stage and moves each stage one place along; nothing else changes the chain while reset is inactive.
- R2: With control value D = BASE + tap_code + ext_quarter, the value of `sig_out` after edge m equals `sig_in` sampled at edge m-D+1, where tap_code is read as an unsigned binary number.
- R3: Tap bit i adds 2^i cycles: bit 0 is a quarter gate (1 cycle), bit 1 is a half gate (2 cycles), and bits 2 to 6 add 1, 2, 4, 8 and 16 gates (4 to 64 cycles).
- R4: With all seven tap bits set and ext_quarter low, the delay is BASE+127 cycles (31.75 gates). With ext_quarter high as well, it is BASE+128 cycles (32 gates), the largest setting.
- R5: Raising the tap code by one raises the delay by exactly one cycle, across all 128 codes.
- R6: When `force_low` is high before an edge, `sig_out` is 0 after that edge. Once it is low again, the output carries the delayed stream without any loss.
- R7: A change of tap code or ext_quarter applies from the next edge, and bits already in the chain keep their stage positions.
- R8: While `rst_n` is low at an edge, the chain is cleared, the tap code and ext_quarter registers are zeroed, force_low is cleared, and `sig_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is a quarter gate delay |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Signal to be delayed |
| tap_code | input | 7 | Delay code in quarter-gate units |
| ext_quarter | input | 1 | Adds one more quarter unit |
| force_low | input | 1 | High holds the output low |
| sig_out | output | 1 | Delayed signal |

## Verification
The hardest case to reach is a setting change while pulses are still in flight. At that moment the output must jump to a different chain stage, without shifting any bit already stored. To get there, the stimulus walks a table of segments back to back, with no flush between them, while driving random data. It also switches from a long tap to a short one while a single pulse is past the new tap point. That pulse must then never appear. A model tracks each setting against the recorded input history, so every such cycle is compared.

// File: rtl/pdl_pkg.sv
// Shared defaults and helpers for the quarter-gate delay line.
package pdl_pkg;
    localparam int unsigned DEF_BASE  = 4;
    localparam int unsigned DEF_TAP_W = 7;

    // Deepest delay in cycles: base latency plus full code range plus extra quarter.
    function automatic int unsigned max_delay(input int unsigned base, input int unsigned tap_w);
        return base + (32'd1 << tap_w);
    endfunction
endpackage

// File: rtl/pdl_ctrl_reg.sv
// Control capture: registers the tap code, extra-quarter select and force-low
// at every edge, so that a new setting applies from the next edge.
// Assumes a synchronous active-low reset.
module pdl_ctrl_reg #(
    parameter int unsigned TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAP_W-1:0] tap_in,
    input  logic             ext_in,
    input  logic             hold_in,
    output logic [TAP_W-1:0] tap_q,
    output logic             ext_q,
    output logic             hold_q
);
    // Capture control inputs; reset selects the shortest delay, output not forced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q  <= '0;
            ext_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            tap_q  <= tap_in;
            ext_q  <= ext_in;
            hold_q <= hold_in;
        end
    end
endmodule

// File: rtl/pdl_shift_chain.sv
// Shift chain: stage 0 takes the input, each later stage takes its neighbour.
// Stage k holds the input sampled k edges before the latest one.
// Assumes a synchronous active-low reset that clears every stage.
module pdl_shift_chain #(
    parameter int unsigned DEPTH = 132
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [DEPTH-1:0] stages
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            // First stage samples the incoming signal.
            always_ff @(posedge clk) begin
                if (!rst_n) stages[s] <= 1'b0;
                else        stages[s] <= din;
            end
        end else begin : g_body
            // Later stages copy the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stages[s] <= 1'b0;
                else        stages[s] <= stages[s-1];
            end
        end
    end
endmodule

// File: rtl/pdl_tap_sel.sv
// Tap select: turns the captured code into a delay, picks stage delay-1, and
// forces zero while hold is set. Assumes BASE >= 2 and DEPTH = BASE + 2**TAP_W.
module pdl_tap_sel #(
    parameter int unsigned BASE  = 4,
    parameter int unsigned TAP_W = 7,
    parameter int unsigned DEPTH = 132
) (
    input  logic [DEPTH-1:0] stages,
    input  logic [TAP_W-1:0] tap_q,
    input  logic             ext_q,
    input  logic             hold_q,
    output logic             dout
);
    localparam int unsigned IDX_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0] dly;
    logic [IDX_W-1:0] idx;
    logic             picked;

    // Delay in cycles and the chain stage that carries it.
    always_comb begin
        dly    = IDX_W'(BASE) + IDX_W'(tap_q) + IDX_W'(ext_q);
        idx    = dly - IDX_W'(1);
        picked = stages[idx];
        dout   = hold_q ? 1'b0 : picked;
    end
endmodule

// File: rtl/prog_delay_line.sv
// Quarter-gate programmable delay line top: control capture, shift chain and
// tap select. One cycle equals a quarter gate. Assumes BASE >= 2.
module prog_delay_line #(
    parameter int unsigned BASE  = pdl_pkg::DEF_BASE,
    parameter int unsigned TAP_W = pdl_pkg::DEF_TAP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [TAP_W-1:0] tap_code,
    input  logic             ext_quarter,
    input  logic             force_low,
    output logic             sig_out
);
    localparam int unsigned DEPTH = pdl_pkg::max_delay(BASE, TAP_W);

    logic [TAP_W-1:0] tap_q;
    logic             ext_q;
    logic             hold_q;
    logic [DEPTH-1:0] chain_w;

    pdl_ctrl_reg #(.TAP_W(TAP_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_in  (tap_code),
        .ext_in  (ext_quarter),
        .hold_in (force_low),
        .tap_q   (tap_q),
        .ext_q   (ext_q),
        .hold_q  (hold_q)
    );

    pdl_shift_chain #(.DEPTH(DEPTH)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (sig_in),
        .stages (chain_w)
    );

    pdl_tap_sel #(.BASE(BASE), .TAP_W(TAP_W), .DEPTH(DEPTH)) u_sel (
        .stages (chain_w),
        .tap_q  (tap_q),
        .ext_q  (ext_q),
        .hold_q (hold_q),
        .dout   (sig_out)
    );
endmodule

// File: rtl/pdl_checker.sv
// Property checker for the delay line, bound to every prog_delay_line instance.
module pdl_checker #(
    parameter int unsigned BASE  = 4,
    parameter int unsigned TAP_W = 7,
    parameter int unsigned DEPTH = 132
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sig_in,
    input logic             force_low,
    input logic             sig_out,
    input logic [DEPTH-1:0] chain,
    input logic [TAP_W-1:0] tap_q,
    input logic             ext_q,
    input logic             hold_q
);
    localparam int unsigned IDX_W = $clog2(DEPTH + 1);
    logic [IDX_W-1:0] idx_m2;
    assign idx_m2 = IDX_W'(BASE - 2) + IDX_W'(tap_q) + IDX_W'(ext_q);

    // R8: a reset edge leaves an empty chain and a low output.
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (sig_out == 1'b0 && chain == '0));

    // R6: force-low seen at an edge gives a low output after it.
    p_force_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        force_low |=> sig_out == 1'b0);

    // R1: the head stage holds the input from the previous edge.
    p_chain_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> chain[0] == $past(sig_in));

    // R1: the tail stage holds what its neighbour held an edge earlier.
    p_chain_tail_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> chain[DEPTH-1] == $past(chain[DEPTH-2]));

    // R7: with a steady setting, the output is the bit one stage nearer the head last cycle.
    p_in_flight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !hold_q && $stable(tap_q) && $stable(ext_q))
        |-> sig_out == $past(chain[idx_m2]));
endmodule

bind prog_delay_line pdl_checker #(.BASE(BASE), .TAP_W(TAP_W), .DEPTH(DEPTH)) u_pdl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_in    (sig_in),
    .force_low (force_low),
    .sig_out   (sig_out),
    .chain     (chain_w),
    .tap_q     (tap_q),
    .ext_q     (ext_q),
    .hold_q    (hold_q)
);

// File: tb/tb_prog_delay_line.sv
module tb_prog_delay_line;
    localparam int BASE  = 4;
    localparam int TAP_W = 7;
    localparam int DEPTH = BASE + (1 << TAP_W);
    localparam int RING  = 256;

    // Segment table: {tap[16:10], ext[9], hold[8], length[7:0]}
    localparam logic [16:0] VEC [12] = '{
        {7'h00, 1'b0, 1'b0, 8'd40},  {7'h01, 1'b0, 1'b0, 8'd40},
        {7'h02, 1'b0, 1'b0, 8'd40},  {7'h55, 1'b0, 1'b0, 8'd160},
        {7'h2A, 1'b1, 1'b0, 8'd160}, {7'h7F, 1'b0, 1'b0, 8'd150},
        {7'h7F, 1'b1, 1'b0, 8'd150}, {7'h40, 1'b0, 1'b1, 8'd20},
        {7'h40, 1'b0, 1'b0, 8'd150}, {7'h10, 1'b1, 1'b0, 8'd60},
        {7'h03, 1'b0, 1'b0, 8'd60},  {7'h00, 1'b1, 1'b0, 8'd30}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sig_in = 1'b0;
    logic [TAP_W-1:0] tap_code = '0;
    logic             ext_quarter = 1'b0;
    logic             force_low = 1'b0;
    logic             sig_out;

    int checks = 0;
    int errors = 0;
    int cyc = 1000;
    logic hist [RING];
    int cur_d = BASE;
    logic cur_hold = 1'b0;
    logic cur_rst = 1'b1;

    always #4 clk = ~clk;

    prog_delay_line #(.BASE(BASE), .TAP_W(TAP_W)) dut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .tap_code(tap_code),
        .ext_quarter(ext_quarter), .force_low(force_low), .sig_out(sig_out)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0b expected %0b", tag, cyc, act, exp);
        end
    endtask

    // One cycle: drive at negedge, record at posedge, compare at the next negedge.
    task automatic step(input logic d, input logic [TAP_W-1:0] t, input logic e,
                        input logic h, input logic r, input string tag);
        logic exp;
        sig_in = d; tap_code = t; ext_quarter = e; force_low = h; rst_n = r;
        @(posedge clk);
        cyc++;
        if (!r) begin
            hist[cyc % RING] = 1'b0;
            cur_d = BASE; cur_hold = 1'b0; cur_rst = 1'b1;
        end else begin
            hist[cyc % RING] = d;
            cur_d = BASE + int'(t) + int'(e); cur_hold = h; cur_rst = 1'b0;
        end
        @(negedge clk);
        if (cur_rst || cur_hold) exp = 1'b0;
        else exp = hist[(cyc - cur_d + 1) % RING];
        check(tag, sig_out, exp);
    endtask

    // Flush, send a single pulse, and count cycles until it arrives.
    task automatic measure(input logic [TAP_W-1:0] t, input logic e, output int n);
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, t, e, 1'b0, 1'b1, "R2 flush");
        step(1'b1, t, e, 1'b0, 1'b1, "R2 pulse");
        n = 1;
        while (sig_out !== 1'b1 && n < DEPTH + 4) begin
            step(1'b0, t, e, 1'b0, 1'b1, "R2 pulse wait");
            n++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        int prev;
        for (int i = 0; i < RING; i++) hist[i] = 1'b0;

        // R8: reset with busy inputs keeps the output low and clears the chain.
        for (int i = 0; i < 4; i++) step(1'b1, 7'h7F, 1'b1, 1'b0, 1'b0, "R8 reset");
        for (int i = 0; i < BASE + 2; i++) step(1'b0, 7'h00, 1'b0, 1'b0, 1'b1, "R8 after reset");

        // R1/R2/R6/R7: table walk with random data, no flush between segments.
        for (int v = 0; v < 12; v++) begin
            for (int k = 0; k < int'(VEC[v][7:0]); k++)
                step(1'($urandom % 2), VEC[v][16:10], VEC[v][9], VEC[v][8], 1'b1, "R1/R2/R7 stream");
        end

        // R3: each tap bit alone adds its binary weight.
        for (int b = 0; b < TAP_W; b++) begin
            measure(7'(1 << b), 1'b0, n);
            check("R3 bit weight", n == BASE + (1 << b), 1'b1);
        end

        // R4: 31.75 gates and 32 gates at the top of the range.
        measure(7'h7F, 1'b0, n);
        check("R4 all taps", n == BASE + 127, 1'b1);
        measure(7'h7F, 1'b1, n);
        check("R4 maximum", n == BASE + 128, 1'b1);

        // R5: a sweep over all codes, each one cycle longer than the last.
        prev = 0;
        for (int c = 0; c < (1 << TAP_W); c++) begin
            measure(7'(c), 1'b0, n);
            if (c > 0) check("R5 monotonic step", n == prev + 1, 1'b1);
            prev = n;
        end

        // R6: force-low hides a pulse arriving while set, then the stream resumes.
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 7'd10, 1'b0, 1'b0, 1'b1, "R6 flush");
        step(1'b1, 7'd10, 1'b0, 1'b0, 1'b1, "R6 pulse");
        for (int i = 0; i < BASE + 12; i++) step(1'b0, 7'd10, 1'b0, 1'b1, 1'b1, "R6 held low");
        for (int i = 0; i < 40; i++) step(1'($urandom % 2), 7'd10, 1'b0, 1'b0, 1'b1, "R6 resume");

        // R7: shorten the tap past an in-flight pulse, so it must never appear.
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 7'd100, 1'b0, 1'b0, 1'b1, "R7 flush");
        step(1'b1, 7'd100, 1'b0, 1'b0, 1'b1, "R7 pulse");
        for (int i = 0; i < 30; i++) step(1'b0, 7'd100, 1'b0, 1'b0, 1'b1, "R7 travel");
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, 7'd20, 1'b0, 1'b0, 1'b1, "R7 retap");
            check("R7 lost pulse stays low", sig_out, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule